// File: doc/BRIEF.md
# USB Controller Control Register File

This block is a 32-bit register file placed next to a USB host controller. It holds the static settings the controller samples: a four-bit bus filter bypass, five port strap bits, a six-bit frame length adjust value, an endian select, a coherency select and a bus master enable. Software reads and writes these settings through a simple word-wide register port. Each access gets a response one clock later.

It also contains a two-source interrupt unit, for a host system error and an address decode error. Software sees four registers: status, mask, enable and disable. Status bits are cleared by writing 1s. The mask can only be changed through the enable register, which clears mask bits, and the disable register, which sets them. A single level-sensitive interrupt line reports any pending source that is not masked. An access to an unused offset, or an access that is not a full aligned word, reads as zero. When the error-response enable bit is set, such an access also returns an error and raises the address decode error.

Top module: `usbc_ctl_regfile`

## Requirements
- R1: After reset the frame length adjust output is 0x20, bus master enable is 1, the interrupt mask reads 0x3, the interrupt line is 0, and every other setting and status bit is 0.
- R2: A full-word write to byte offset 0x30 (bits 3:0 to filter bypass), 0x34 (bits 4:0 to port straps), 0x38 (bits 5:0 to frame length adjust), 0x40 (bit 0 to endian select), 0x44 (bit 0 to coherency select), 0x48 (bit 0 to bus master enable) or 0x60 (bit 0 to error-response enable) updates that field. The field shows on its output pin in the cycle after the write, and it reads back at the same offset.
- R3: Bits above each field are reserved. They read as 0 and ignore writes.
- R4: Interrupt status sits at 0x64, with bit 1 for the host system error and bit 0 for the address decode error. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R5: The mask at 0x68 ignores direct writes. Writing 1s to 0x6C clears the matching mask bits, and writing 1s to 0x70 sets them.
- R6: Offsets 0x6C and 0x70 always read as 0.
- R7: The interrupt output is the registered OR of the status bits whose mask bit is 0. It changes one clock after the status or mask change.
- R8: A one-cycle pulse on host_err_i sets status bit 1, and a pulse on addr_err_i sets status bit 0. If a set and a write-one-to-clear of the same bit happen in the same cycle, the set wins.
- R9: Only accesses with bus_size_i = 2 (word) and bus_addr_i[1:0] = 0 are decoded. Size codes 0 (byte), 1 (half) and 3 count as undecoded, as do unaligned addresses. Writes of this kind change nothing, and reads of this kind return 0.
- R10: An undecoded offset reads as 0 and ignores writes. If the error-response enable is 0, no error is signalled. If it is 1, bus_err_o is 1 in the response and status bit 0 is set.
- R11: Every request gets bus_rvalid_o exactly one cycle later. For a read, bus_rdata_o holds the register value from before that cycle's update. For a write, bus_rdata_o is 0.
- R12: Offset 0x78 is decoded. It reads 0, ignores writes, and never returns an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid_i | input | 1 | Request strobe, one cycle per access |
| bus_write_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_size_i | input | 2 | Access size code (2 = word) |
| bus_wdata_i | input | 32 | Write data |
| bus_rvalid_o | output | 1 | Response valid, one cycle after request |
| bus_rdata_o | output | 32 | Read data |
| bus_err_o | output | 1 | Error response |
| host_err_i | input | 1 | Host system error pulse |
| addr_err_i | input | 1 | External address decode error pulse |
| filt_bypass_o | output | 4 | Bus filter bypass setting |
| port_strap_o | output | 5 | Port strap bits |
| fladj_o | output | 6 | Frame length adjust value |
| endian_sel_o | output | 1 | Endian select |
| coh_sel_o | output | 1 | Coherency select |
| bus_master_en_o | output | 1 | Bus master enable |
| irq_o | output | 1 | Level interrupt |

## Verification
The case hardest to reach from the ports is a host error pulse that arrives in the same clock as a software write clearing that status bit. The bench drives both on the same falling edge and then reads the status back to confirm the bit stayed set. A second hard case is the address decode error, which is raised inside the block only by undecoded or malformed accesses. To reach it, the bench first enables error responses and then issues a read at an unused offset and a read at an unaligned address, checking both the error response and the status bit it leaves behind. The registered interrupt is checked on both sides of its one-cycle delay.

// File: rtl/usbc_ctl_pkg.sv
package usbc_ctl_pkg;

    localparam int unsigned DW      = 32;
    localparam int unsigned FILT_W  = 4;
    localparam int unsigned STRAP_W = 5;
    localparam int unsigned FLADJ_W = 6;
    localparam int unsigned IRQ_W   = 2;
    // widest writable field; write data above it never reaches a register
    localparam int unsigned FIELD_W = FLADJ_W;

    localparam logic [FLADJ_W-1:0] FLADJ_RST = 6'h20;
    localparam logic [IRQ_W-1:0]   MASK_RST  = '1;

    // interrupt source bit positions (visible to software)
    localparam int unsigned SRC_ADE = 0;
    localparam int unsigned SRC_HSE = 1;

    // byte offsets
    localparam int unsigned OFF_FILT   = 'h30;
    localparam int unsigned OFF_STRAP  = 'h34;
    localparam int unsigned OFF_FLADJ  = 'h38;
    localparam int unsigned OFF_ENDIAN = 'h40;
    localparam int unsigned OFF_COH    = 'h44;
    localparam int unsigned OFF_BME    = 'h48;
    localparam int unsigned OFF_SLVERR = 'h60;
    localparam int unsigned OFF_ISTAT  = 'h64;
    localparam int unsigned OFF_IMASK  = 'h68;
    localparam int unsigned OFF_IEN    = 'h6C;
    localparam int unsigned OFF_IDIS   = 'h70;
    localparam int unsigned OFF_SPARE  = 'h78;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_FILT,
        SEL_STRAP,
        SEL_FLADJ,
        SEL_ENDIAN,
        SEL_COH,
        SEL_BME,
        SEL_SLVERR,
        SEL_ISTAT,
        SEL_IMASK,
        SEL_IEN,
        SEL_IDIS,
        SEL_SPARE
    } reg_sel_e;

    typedef struct packed {
        logic [FILT_W-1:0]  filt;
        logic [STRAP_W-1:0] strap;
        logic [FLADJ_W-1:0] fladj;
        logic               endian;
        logic               coh;
        logic               bme;
        logic               slverr;
    } cfg_t;

    typedef struct packed {
        logic [IRQ_W-1:0] stat;
        logic [IRQ_W-1:0] mask;
        logic             irq;
    } irq_state_t;

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] rdata;
        logic          err;
    } resp_t;

endpackage

// File: rtl/usbc_ctl_decode.sv
module usbc_ctl_decode
    import usbc_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              valid_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    output reg_sel_e          sel_o,
    output logic              bad_o
);

    localparam int unsigned WORD_W = ADDR_W - 2;

    function automatic logic [WORD_W-1:0] widx(input int unsigned off);
        return WORD_W'(off >> 2);
    endfunction

    reg_sel_e sel_d;
    logic     well_formed;

    always_comb begin
        well_formed = (size_i == SZ_WORD) && (addr_i[1:0] == 2'b00);
        sel_d       = SEL_NONE;
        if (well_formed) begin
            case (addr_i[ADDR_W-1:2])
                widx(OFF_FILT):   sel_d = SEL_FILT;
                widx(OFF_STRAP):  sel_d = SEL_STRAP;
                widx(OFF_FLADJ):  sel_d = SEL_FLADJ;
                widx(OFF_ENDIAN): sel_d = SEL_ENDIAN;
                widx(OFF_COH):    sel_d = SEL_COH;
                widx(OFF_BME):    sel_d = SEL_BME;
                widx(OFF_SLVERR): sel_d = SEL_SLVERR;
                widx(OFF_ISTAT):  sel_d = SEL_ISTAT;
                widx(OFF_IMASK):  sel_d = SEL_IMASK;
                widx(OFF_IEN):    sel_d = SEL_IEN;
                widx(OFF_IDIS):   sel_d = SEL_IDIS;
                widx(OFF_SPARE):  sel_d = SEL_SPARE;
                default:          sel_d = SEL_NONE;
            endcase
        end
    end

    assign sel_o = sel_d;
    assign bad_o = valid_i && (sel_d == SEL_NONE);

endmodule

// File: rtl/usbc_ctl_cfg.sv
module usbc_ctl_cfg
    import usbc_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  reg_sel_e           sel_i,
    input  logic [FIELD_W-1:0] wdata_i,
    output cfg_t               cfg_o
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            case (sel_i)
                SEL_FILT:   cfg_d.filt   = wdata_i[FILT_W-1:0];
                SEL_STRAP:  cfg_d.strap  = wdata_i[STRAP_W-1:0];
                SEL_FLADJ:  cfg_d.fladj  = wdata_i[FLADJ_W-1:0];
                SEL_ENDIAN: cfg_d.endian = wdata_i[0];
                SEL_COH:    cfg_d.coh    = wdata_i[0];
                SEL_BME:    cfg_d.bme    = wdata_i[0];
                SEL_SLVERR: cfg_d.slverr = wdata_i[0];
                default:    cfg_d        = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q        <= '0;
            cfg_q.fladj  <= FLADJ_RST;
            cfg_q.bme    <= 1'b1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/usbc_ctl_irq.sv
module usbc_ctl_irq
    import usbc_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  reg_sel_e         sel_i,
    input  logic [IRQ_W-1:0] wdata_i,
    input  logic             hse_evt_i,
    input  logic             ade_evt_i,
    output logic [IRQ_W-1:0] stat_o,
    output logic [IRQ_W-1:0] mask_o,
    output logic             irq_o
);

    irq_state_t st_d, st_q;
    logic [IRQ_W-1:0] set_vec;
    logic [IRQ_W-1:0] clr_vec;

    always_comb begin
        set_vec          = '0;
        set_vec[SRC_HSE] = hse_evt_i;
        set_vec[SRC_ADE] = ade_evt_i;
        clr_vec = (wr_en_i && sel_i == SEL_ISTAT) ? wdata_i : '0;

        st_d = st_q;
        // a set request outranks a clear of the same bit
        for (int b = 0; b < int'(IRQ_W); b++) begin
            st_d.stat[b] = set_vec[b] | (st_q.stat[b] & ~clr_vec[b]);
        end
        if (wr_en_i && sel_i == SEL_IEN) begin
            st_d.mask = st_q.mask & ~wdata_i;
        end else if (wr_en_i && sel_i == SEL_IDIS) begin
            st_d.mask = st_q.mask | wdata_i;
        end
        st_d.irq = |(st_q.stat & ~st_q.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= MASK_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o = st_q.stat;
    assign mask_o = st_q.mask;
    assign irq_o  = st_q.irq;

endmodule

// File: rtl/usbc_ctl_regfile.sv
module usbc_ctl_regfile
    import usbc_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid_i,
    input  logic              bus_write_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [1:0]        bus_size_i,
    input  logic [31:0]       bus_wdata_i,
    output logic              bus_rvalid_o,
    output logic [31:0]       bus_rdata_o,
    output logic              bus_err_o,
    input  logic              host_err_i,
    input  logic              addr_err_i,
    output logic [3:0]        filt_bypass_o,
    output logic [4:0]        port_strap_o,
    output logic [5:0]        fladj_o,
    output logic              endian_sel_o,
    output logic              coh_sel_o,
    output logic              bus_master_en_o,
    output logic              irq_o
);

    reg_sel_e         sel;
    logic             dec_bad;
    logic             wr_en;
    logic             bad_acc;
    logic             slverr_en;
    cfg_t             cfg;
    logic [IRQ_W-1:0] irq_stat;
    logic [IRQ_W-1:0] irq_mask;
    logic [DW-1:0]    rd_mux;
    resp_t            resp_d, resp_q;
    logic             unused_wdata;

    assign unused_wdata = ^bus_wdata_i[DW-1:FIELD_W];

    usbc_ctl_decode #(.ADDR_W(ADDR_W)) dec_i (
        .valid_i (bus_valid_i),
        .addr_i  (bus_addr_i),
        .size_i  (bus_size_i),
        .sel_o   (sel),
        .bad_o   (dec_bad)
    );

    assign wr_en     = bus_valid_i && bus_write_i;
    assign slverr_en = cfg.slverr;
    assign bad_acc   = dec_bad && slverr_en;

    usbc_ctl_cfg cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en),
        .sel_i   (sel),
        .wdata_i (bus_wdata_i[FIELD_W-1:0]),
        .cfg_o   (cfg)
    );

    usbc_ctl_irq irq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .sel_i     (sel),
        .wdata_i   (bus_wdata_i[IRQ_W-1:0]),
        .hse_evt_i (host_err_i),
        .ade_evt_i (addr_err_i | bad_acc),
        .stat_o    (irq_stat),
        .mask_o    (irq_mask),
        .irq_o     (irq_o)
    );

    // read mux: values before this cycle's update
    always_comb begin
        case (sel)
            SEL_FILT:   rd_mux = DW'(cfg.filt);
            SEL_STRAP:  rd_mux = DW'(cfg.strap);
            SEL_FLADJ:  rd_mux = DW'(cfg.fladj);
            SEL_ENDIAN: rd_mux = DW'(cfg.endian);
            SEL_COH:    rd_mux = DW'(cfg.coh);
            SEL_BME:    rd_mux = DW'(cfg.bme);
            SEL_SLVERR: rd_mux = DW'(cfg.slverr);
            SEL_ISTAT:  rd_mux = DW'(irq_stat);
            SEL_IMASK:  rd_mux = DW'(irq_mask);
            default:    rd_mux = '0;
        endcase
    end

    always_comb begin
        resp_d.valid = bus_valid_i;
        resp_d.err   = bad_acc;
        resp_d.rdata = (bus_valid_i && !bus_write_i) ? rd_mux : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign bus_rvalid_o    = resp_q.valid;
    assign bus_rdata_o     = resp_q.rdata;
    assign bus_err_o       = resp_q.err;
    assign filt_bypass_o   = cfg.filt;
    assign port_strap_o    = cfg.strap;
    assign fladj_o         = cfg.fladj;
    assign endian_sel_o    = cfg.endian;
    assign coh_sel_o       = cfg.coh;
    assign bus_master_en_o = cfg.bme;

endmodule

// File: rtl/usbc_ctl_regfile_chk.sv
module usbc_ctl_regfile_chk
    import usbc_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid_i,
    input logic              bus_write_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic              bus_rvalid_o,
    input logic [31:0]       bus_rdata_o,
    input logic              bus_err_o,
    input logic              host_err_i,
    input logic              irq_o,
    input logic [IRQ_W-1:0]  stat,
    input logic [IRQ_W-1:0]  mask,
    input logic              slverr
);

    // R3
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid_o |-> bus_rdata_o[31:FIELD_W] == '0);

    // R5
    mask_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mask) |-> $past(bus_valid_i && bus_write_i &&
            (bus_addr_i == ADDR_W'(OFF_IEN) || bus_addr_i == ADDR_W'(OFF_IDIS))));

    // R6
    ien_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rvalid_o && $past(bus_valid_i && !bus_write_i &&
            (bus_addr_i == ADDR_W'(OFF_IEN) || bus_addr_i == ADDR_W'(OFF_IDIS))))
        |-> bus_rdata_o == '0);

    // R7
    irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past(|(stat & ~mask)));

    // R8
    hse_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_err_i |=> stat[SRC_HSE]);

    // R10
    err_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err_o |-> $past(slverr) && stat[SRC_ADE]);

    // R11
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid_i |=> bus_rvalid_o);

endmodule

bind usbc_ctl_regfile usbc_ctl_regfile_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_valid_i  (bus_valid_i),
    .bus_write_i  (bus_write_i),
    .bus_addr_i   (bus_addr_i),
    .bus_rvalid_o (bus_rvalid_o),
    .bus_rdata_o  (bus_rdata_o),
    .bus_err_o    (bus_err_o),
    .host_err_i   (host_err_i),
    .irq_o        (irq_o),
    .stat         (irq_stat),
    .mask         (irq_mask),
    .slverr       (slverr_en)
);

// File: tb/usbc_ctl_regfile_tb.sv
module usbc_ctl_regfile_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid_i = 1'b0;
    logic        bus_write_i = 1'b0;
    logic [7:0]  bus_addr_i = '0;
    logic [1:0]  bus_size_i = 2'd2;
    logic [31:0] bus_wdata_i = '0;
    logic        bus_rvalid_o;
    logic [31:0] bus_rdata_o;
    logic        bus_err_o;
    logic        host_err_i = 1'b0;
    logic        addr_err_i = 1'b0;
    logic [3:0]  filt_bypass_o;
    logic [4:0]  port_strap_o;
    logic [5:0]  fladj_o;
    logic        endian_sel_o;
    logic        coh_sel_o;
    logic        bus_master_en_o;
    logic        irq_o;

    int compared   = 0;
    int mismatched = 0;
    bit done       = 1'b0;

    typedef struct {
        logic [31:0] rdata;
        logic        err;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    usbc_ctl_regfile #(.ADDR_W(8)) dut_i (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // driver: one request, expected response pushed to the scoreboard
    task automatic acc(input logic wr, input logic [7:0] addr, input logic [1:0] sz,
                       input logic [31:0] wd, input logic [31:0] exp_rd,
                       input logic exp_err, input string tag);
        exp_t e;
        @(negedge clk);
        bus_valid_i = 1'b1;
        bus_write_i = wr;
        bus_addr_i  = addr;
        bus_size_i  = sz;
        bus_wdata_i = wd;
        e.rdata = exp_rd;
        e.err   = exp_err;
        e.tag   = tag;
        sb_q.push_back(e);
        @(negedge clk);
        bus_valid_i = 1'b0;
        bus_write_i = 1'b0;
    endtask

    task automatic wr(input logic [7:0] addr, input logic [31:0] d, input string tag);
        acc(1'b1, addr, 2'd2, d, 32'h0, 1'b0, tag);
    endtask

    task automatic rd(input logic [7:0] addr, input logic [31:0] exp, input string tag);
        acc(1'b0, addr, 2'd2, 32'h0, exp, 1'b0, tag);
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    // monitor: pops and compares every response
    always @(negedge clk) begin
        if (rst_n && bus_rvalid_o) begin
            compared++;
            if (sb_q.size() == 0) begin
                mismatched++;
                $display("FAIL R11 unexpected response act=%h exp=none", bus_rdata_o);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (bus_rdata_o !== e.rdata || bus_err_o !== e.err) begin
                    mismatched++;
                    $display("FAIL %s act=%h/%b exp=%h/%b", e.tag, bus_rdata_o, bus_err_o,
                             e.rdata, e.err);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        // R1 reset state
        chk("R1 filt", 32'(filt_bypass_o), 32'h0);
        chk("R1 strap", 32'(port_strap_o), 32'h0);
        chk("R1 fladj", 32'(fladj_o), 32'h20);
        chk("R1 endian", 32'(endian_sel_o), 32'h0);
        chk("R1 coh", 32'(coh_sel_o), 32'h0);
        chk("R1 bme", 32'(bus_master_en_o), 32'h1);
        chk("R1 irq", 32'(irq_o), 32'h0);
        rd(8'h68, 32'h3, "R1 mask");
        rd(8'h64, 32'h0, "R1 status");
        rd(8'h38, 32'h20, "R1 fladj read");

        // R2 / R3 configuration writes
        wr(8'h30, 32'hFFFF_FFFF, "R2 filt wr");
        chk("R2 R3 filt pin", 32'(filt_bypass_o), 32'hF);
        rd(8'h30, 32'hF, "R3 filt read");
        wr(8'h34, 32'h0000_00A5, "R2 strap wr");
        chk("R3 strap pin", 32'(port_strap_o), 32'h05);
        rd(8'h34, 32'h05, "R3 strap read");
        wr(8'h38, 32'hFFFF_FF3F, "R2 fladj wr");
        chk("R2 fladj pin", 32'(fladj_o), 32'h3F);
        wr(8'h40, 32'h3, "R2 endian wr");
        chk("R2 endian pin", 32'(endian_sel_o), 32'h1);
        wr(8'h44, 32'h1, "R2 coh wr");
        chk("R2 coh pin", 32'(coh_sel_o), 32'h1);
        wr(8'h48, 32'h0, "R2 bme wr");
        chk("R2 bme pin", 32'(bus_master_en_o), 32'h0);
        rd(8'h40, 32'h1, "R2 endian read");

        // R9 malformed accesses, error responses off
        acc(1'b1, 8'h30, 2'd0, 32'h3, 32'h0, 1'b0, "R9 byte wr");
        chk("R9 filt unchanged", 32'(filt_bypass_o), 32'hF);
        acc(1'b0, 8'h30, 2'd1, 32'h0, 32'h0, 1'b0, "R9 half rd");
        acc(1'b1, 8'h39, 2'd2, 32'h1, 32'h0, 1'b0, "R9 unaligned wr");
        chk("R9 fladj unchanged", 32'(fladj_o), 32'h3F);

        // R10 undecoded, error responses off
        rd(8'h3C, 32'h0, "R10 undecoded rd");
        rd(8'h64, 32'h0, "R10 no status when off");

        // R10 / R9 / R12 with error responses on
        wr(8'h60, 32'h1, "R2 slverr wr");
        rd(8'h60, 32'h1, "R2 slverr read");
        acc(1'b0, 8'h74, 2'd2, 32'h0, 32'h0, 1'b1, "R10 undecoded err");
        rd(8'h64, 32'h1, "R10 ade status");
        acc(1'b0, 8'h31, 2'd2, 32'h0, 32'h0, 1'b1, "R9 unaligned err");
        acc(1'b1, 8'h78, 2'd2, 32'hFFFF_FFFF, 32'h0, 1'b0, "R12 spare wr");
        rd(8'h78, 32'h0, "R12 spare rd");
        idle();
        chk("R7 masked irq", 32'(irq_o), 32'h0);

        // R5 / R6 mask handling
        wr(8'h68, 32'h0, "R5 mask direct wr");
        rd(8'h68, 32'h3, "R5 mask unchanged");
        wr(8'h6C, 32'h2, "R5 enable wr");
        rd(8'h68, 32'h1, "R5 mask after enable");
        rd(8'h6C, 32'h0, "R6 enable read");
        rd(8'h70, 32'h0, "R6 disable read");

        // R8 / R7 host error pulse
        @(negedge clk); host_err_i = 1'b1;
        @(negedge clk); host_err_i = 1'b0;
        chk("R7 irq lags status", 32'(irq_o), 32'h0);
        idle();
        chk("R7 R8 irq raised", 32'(irq_o), 32'h1);
        rd(8'h64, 32'h3, "R8 status set");

        // R4 write-one-to-clear
        wr(8'h64, 32'h1, "R4 clear ade");
        rd(8'h64, 32'h2, "R4 write 0 keeps bit");
        chk("R7 irq still high", 32'(irq_o), 32'h1);
        wr(8'h64, 32'h2, "R4 clear hse");
        chk("R7 irq one cycle late", 32'(irq_o), 32'h1);
        idle();
        chk("R4 R7 irq cleared", 32'(irq_o), 32'h0);

        // R8 set beats clear in the same cycle
        begin
            exp_t e;
            @(negedge clk);
            bus_valid_i = 1'b1; bus_write_i = 1'b1; bus_addr_i = 8'h64;
            bus_size_i = 2'd2; bus_wdata_i = 32'h2; host_err_i = 1'b1;
            e.rdata = 32'h0; e.err = 1'b0; e.tag = "R8 collide wr";
            sb_q.push_back(e);
            @(negedge clk);
            bus_valid_i = 1'b0; bus_write_i = 1'b0; host_err_i = 1'b0;
        end
        rd(8'h64, 32'h2, "R8 set wins");
        chk("R8 irq after collide", 32'(irq_o), 32'h1);

        // R5 disable sets mask
        wr(8'h70, 32'h2, "R5 disable wr");
        idle();
        chk("R5 R7 irq masked", 32'(irq_o), 32'h0);
        rd(8'h68, 32'h3, "R5 mask after disable");

        // R8 external decode error pulse
        wr(8'h6C, 32'h1, "R5 enable ade");
        @(negedge clk); addr_err_i = 1'b1;
        @(negedge clk); addr_err_i = 1'b0;
        idle();
        chk("R8 R7 ade irq", 32'(irq_o), 32'h1);
        rd(8'h64, 32'h3, "R8 ade status");

        repeat (3) idle();
        chk("R11 all responses seen", 32'(sb_q.size()), 32'h0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule